// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2,048 two-bit saturating counters. Each counter is shared by one aligned pair of 4-byte instructions, so the table covers a 16 KiB window of code before two addresses alias. The fetch stage presents an address on the lookup port and gets a taken or not-taken guess back in the same cycle. No clock edge lies between the address and the answer, and every lookup is answered from the table; nothing bypasses it.

When a branch resolves, the execute stage presents the branch address and its real outcome with a valid strobe. On that clock edge the addressed counter moves one step toward the outcome and stops at either end of its range. A counter resting at an extreme therefore needs two consecutive wrong guesses before its prediction changes direction. This keeps loop-closing branches predicted taken across the single not-taken exit of each loop.

Top module: `branch_dir_predictor`

## Requirements
- R1: A synchronous reset sets every counter to the weak not-taken value 01. After reset every address predicts not-taken, and a single taken update then makes that address predict taken.
- R2: The table index is address bits [13:3]. Bits [2:0] and bits [31:14] take no part in the lookup or the update. Two instructions in the same aligned 8-byte pair share a counter, and addresses 16 KiB apart alias.
- R3: An update changes only the counter it addresses. Neighbouring pairs keep their predictions.
- R4: Counter values 00 and 01 predict not-taken. Values 10 and 11 predict taken.
- R5: A taken update adds one to the counter and holds it at 11.
- R6: A not-taken update subtracts one from the counter and holds it at 00.
- R7: From a saturated counter, the prediction reverses only after two consecutive updates against it. A single opposing update that is followed by an agreeing one never reverses it.
- R8: While the update-valid input is low, the update address and outcome have no effect on any counter.
- R9: If a lookup and an update address the same counter in one cycle, the lookup returns the value from before the update. The new value appears from the next cycle on.
- R10: The prediction depends combinationally on the lookup address, so changing the address within a cycle changes the answer in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookup_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | 1 = predicted taken, 0 = predicted not-taken |
| upd_valid | input | 1 | Applies an update on this clock edge |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
A wrong counter value becomes visible on pred_taken only when its slot is looked up. It shows in the same cycle the address is presented, or one cycle after the faulty update. Off-by-one saturation or a broken step function can hide behind a correct prediction bit. It surfaces only after a second or third update drives the counter past where it should stop, so the checks walk each slot through update chains that end on a reversal. Wrong index bits show up as aliasing between addresses that should be separate, or as separation between addresses that should share a slot.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    // Default geometry: 4-byte instructions, one counter per aligned pair.
    localparam int DEF_PC_W     = 32;
    localparam int DEF_IDX_W    = 11;
    localparam int DEF_INSN_LG2 = 2;
    localparam int DEF_PAIR_LG2 = 1;

    // Two-bit saturating counter; the upper bit is the prediction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_AT_RESET = CTR_WEAK_NT;

    // Result of a table read as it travels to the next-state logic.
    typedef struct packed {
        ctr_e state;
        logic taken;
    } ctr_view_t;

    function automatic logic ctr_predicts_taken(input ctr_e c);
        logic [1:0] raw;
        raw = c;
        return raw[1];
    endfunction

    function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
        ctr_e n;
        unique case (c)
            CTR_STRONG_NT: n = taken ? CTR_WEAK_NT   : CTR_STRONG_NT;
            CTR_WEAK_NT:   n = taken ? CTR_WEAK_T    : CTR_STRONG_NT;
            CTR_WEAK_T:    n = taken ? CTR_STRONG_T  : CTR_WEAK_NT;
            default:       n = taken ? CTR_STRONG_T  : CTR_WEAK_T;
        endcase
        return n;
    endfunction

    function automatic ctr_view_t ctr_view(input ctr_e c);
        ctr_view_t v;
        v.state = c;
        v.taken = ctr_predicts_taken(c);
        return v;
    endfunction

endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
    parameter int PC_W  = bdp_pkg::DEF_PC_W,
    parameter int IDX_W = bdp_pkg::DEF_IDX_W,
    parameter int LSB   = bdp_pkg::DEF_INSN_LG2 + bdp_pkg::DEF_PAIR_LG2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int TOP = LSB + IDX_W;

    assign idx = pc[LSB +: IDX_W];

    // Bits outside the index window are deliberately ignored.
    generate
        if (LSB > 0) begin : g_low_drop
            logic unused_low;
            assign unused_low = ^pc[LSB-1:0];
        end
        if (TOP < PC_W) begin : g_high_drop
            logic unused_high;
            assign unused_high = ^pc[PC_W-1:TOP];
        end
    endgenerate
endmodule

// File: rtl/bdp_ctr_next.sv
module bdp_ctr_next
    import bdp_pkg::*;
(
    input  ctr_e cur,
    input  logic outcome,
    input  logic apply,
    output ctr_e nxt,
    output logic write
);
    ctr_view_t view;

    always_comb begin
        view  = ctr_view(cur);
        nxt   = ctr_step(view.state, outcome);
        // Skip the write when the counter is already pinned at the end.
        write = apply && (nxt != view.state);
    end
endmodule

// File: rtl/bdp_table.sv
module bdp_table
    import bdp_pkg::*;
#(
    parameter int IDX_W = bdp_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output ctr_e             rd_a_ctr,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ctr_e             rd_b_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_e             wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_e cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= CTR_AT_RESET;
            end
        end else if (wr_en) begin
            cells[wr_idx] <= wr_ctr;
        end
    end

    // Both read ports see the array as it stands before the edge.
    assign rd_a_ctr = cells[rd_a_idx];
    assign rd_b_ctr = cells[rd_b_idx];
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
    import bdp_pkg::*;
#(
    parameter int PC_W     = bdp_pkg::DEF_PC_W,
    parameter int IDX_W    = bdp_pkg::DEF_IDX_W,
    parameter int INSN_LG2 = bdp_pkg::DEF_INSN_LG2,
    parameter int PAIR_LG2 = bdp_pkg::DEF_PAIR_LG2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int IDX_LSB = INSN_LG2 + PAIR_LG2;

    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] res_idx;
    ctr_e             look_ctr;
    ctr_e             res_ctr;
    ctr_e             res_next;
    logic             res_write;

    bdp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(IDX_LSB)) i_look_index (
        .pc  (lookup_pc),
        .idx (look_idx)
    );

    bdp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(IDX_LSB)) i_res_index (
        .pc  (upd_pc),
        .idx (res_idx)
    );

    bdp_table #(.IDX_W(IDX_W)) i_table (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (look_idx),
        .rd_a_ctr (look_ctr),
        .rd_b_idx (res_idx),
        .rd_b_ctr (res_ctr),
        .wr_en    (res_write),
        .wr_idx   (res_idx),
        .wr_ctr   (res_next)
    );

    bdp_ctr_next i_ctr_next (
        .cur     (res_ctr),
        .outcome (upd_taken),
        .apply   (upd_valid),
        .nxt     (res_next),
        .write   (res_write)
    );

    assign pred_taken = ctr_predicts_taken(look_ctr);
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 11,
    parameter int IDX_LSB = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] lookup_pc,
    input logic            pred_taken,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken
);
    logic fresh;
    logic same_slot;

    always_ff @(posedge clk) begin
        if (rst) fresh <= 1'b1;
        else     fresh <= 1'b0;
    end

    assign same_slot = (lookup_pc[IDX_LSB +: IDX_W] == upd_pc[IDX_LSB +: IDX_W]);

    p_after_reset_weak_nt_r1: assert property (@(posedge clk) disable iff (rst)
        fresh |-> !pred_taken);

    p_other_slot_untouched_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !same_slot) |=> ($stable(lookup_pc) -> $stable(pred_taken)));

    p_taken_keeps_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && same_slot && pred_taken)
        |=> ($stable(lookup_pc) -> pred_taken));

    p_nt_keeps_nt_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && same_slot && !pred_taken)
        |=> ($stable(lookup_pc) -> !pred_taken));

    p_idle_no_change_r8: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> ($stable(lookup_pc) -> $stable(pred_taken)));
endmodule

bind branch_dir_predictor bdp_checker #(
    .PC_W    (PC_W),
    .IDX_W   (IDX_W),
    .IDX_LSB (IDX_LSB)
) i_bdp_checker (
    .clk        (clk),
    .rst        (rst),
    .lookup_pc  (lookup_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
);

// File: tb/test_branch_dir_predictor.sv
module test_branch_dir_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lookup_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    branch_dir_predictor i_branch_dir_predictor (
        .clk        (clk),
        .rst        (rst),
        .lookup_pc  (lookup_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    typedef struct {
        logic [31:0] pc;
        logic        exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    event  chk_ev;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;

    // Monitor: pops expected items and compares them with the output.
    always @(chk_ev) begin
        item_t it;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            checks++;
            if (pred_taken !== it.exp) begin
                errors++;
                $display("FAIL %s pc=%h actual=%b expected=%b",
                         it.tag, it.pc, pred_taken, it.exp);
            end
        end
    end

    // Driver: presents a lookup and queues the expected prediction.
    task automatic expect_pred(input logic [31:0] pc, input logic exp, input string tag);
        item_t it;
        lookup_pc = pc;
        #1;
        it.pc  = pc;
        it.exp = exp;
        it.tag = tag;
        sbq.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    localparam logic [31:0] PA = 32'h0000_1000;
    localparam logic [31:0] PB = 32'h0000_2000;
    localparam logic [31:0] PC = 32'h0000_3000;
    localparam logic [31:0] PD = 32'h0000_4000;
    localparam logic [31:0] PE = 32'h0000_5000;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything weakly not-taken after reset
        expect_pred(32'h0000_0000, 1'b0, "R1 reset lookup low");
        expect_pred(PA,            1'b0, "R1 reset lookup A");
        expect_pred(32'hFFFF_FFF8, 1'b0, "R1 reset lookup top");

        // R1/R4: one taken step from 01 reaches 10 = taken
        resolve(PA, 1'b1);
        expect_pred(PA, 1'b1, "R1 R4 single taken from reset");

        // R2: pair sharing and 16 KiB aliasing; R3: neighbours untouched
        expect_pred(PA + 32'd4,      1'b1, "R2 pair partner shares counter");
        expect_pred(PA + 32'd3,      1'b1, "R2 low bits ignored");
        expect_pred(PA + 32'h4000,   1'b1, "R2 alias 16KiB apart");
        expect_pred(PA + 32'h8000_0000, 1'b1, "R2 top bits ignored");
        expect_pred(PA + 32'd8,      1'b0, "R3 next pair untouched");
        expect_pred(PA - 32'd8,      1'b0, "R3 previous pair untouched");

        // R5 saturation at 11, R7 two mispredictions to reverse
        resolve(PA, 1'b1);
        resolve(PA, 1'b1);
        resolve(PA, 1'b0);
        expect_pred(PA, 1'b1, "R5 R7 first miss keeps taken");
        resolve(PA, 1'b0);
        expect_pred(PA, 1'b0, "R7 R4 second miss reverses to 01");

        // R6 saturation at 00
        resolve(PB, 1'b0);
        resolve(PB, 1'b0);
        resolve(PB, 1'b0);
        resolve(PB, 1'b1);
        expect_pred(PB, 1'b0, "R6 floor held at 00");
        resolve(PB, 1'b1);
        expect_pred(PB, 1'b1, "R6 R7 two takens reverse");

        // R7: isolated misses separated by a hit never reverse
        resolve(PE, 1'b1);
        resolve(PE, 1'b1);
        resolve(PE, 1'b1);
        resolve(PE, 1'b0);
        expect_pred(PE, 1'b1, "R7 isolated miss one");
        resolve(PE, 1'b1);
        resolve(PE, 1'b0);
        expect_pred(PE, 1'b1, "R7 isolated miss two");
        resolve(PE, 1'b0);
        expect_pred(PE, 1'b0, "R7 consecutive misses reverse");

        // R8: payload present but valid low for several edges
        @(negedge clk);
        upd_valid = 1'b0;
        upd_pc    = PC;
        upd_taken = 1'b1;
        repeat (3) @(negedge clk);
        expect_pred(PC, 1'b0, "R8 idle update ignored");
        resolve(PC, 1'b1);
        expect_pred(PC, 1'b1, "R8 slot was still 01");

        // R9: same-cycle lookup and update return the old value
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = PD;
        upd_taken = 1'b1;
        expect_pred(PD, 1'b0, "R9 pre-update value in update cycle");
        @(negedge clk);
        upd_valid = 1'b0;
        expect_pred(PD, 1'b1, "R9 new value next cycle");

        // R10: address switched within one cycle, answer follows
        @(negedge clk);
        expect_pred(PB, 1'b1, "R10 combinational taken slot");
        expect_pred(PA, 1'b0, "R10 combinational not-taken slot");
        expect_pred(PD, 1'b1, "R10 combinational back to taken");

        // R1: reset again restores 01 everywhere
        do_reset();
        expect_pred(PB, 1'b0, "R1 second reset clears taken slot");
        expect_pred(PD, 1'b0, "R1 second reset clears slot D");
        resolve(PB, 1'b1);
        expect_pred(PB, 1'b1, "R1 one step after second reset");

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule